// File: doc/BRIEF.md
# Dual-Slot Instruction Packet Sequencer

This block sits between instruction fetch and the execute stage of a core whose 32-bit fetch word holds either one long operation or two 15-bit short operations. It reads the two-bit format field at the top of the word and chooses the issue pattern. A word can be one long operation, an ordered pair (left slot first or right slot first), or a parallel pair. The block then hands the slots to the execute stage one at a time over a left channel and a right channel. Each channel carries a valid strobe and takes back a done strobe.

When the first slot of a pair finishes, the execute stage reports three flags with its done strobe: a PC redirect, an exception, and a condition result. From these the block decides whether the second slot runs. It pulses one indication when a taken branch drops the second slot of an ordered pair. It pulses another when a false condition test in a parallel pair drops its partner. Opcode meaning stays outside the block. An external decoder looks at the group indices that the block presents and tells it which short slots are condition-test-only operations.

Top module: `dual_slot_seq`

## Requirements
- R1: After asynchronous reset, word_ready is 1, lft_vld, rgt_vld, word_done, skip_br and cond_false are 0, and iss_kind is 0 (none).
- R2: A word with bits [31:30] = 11 is one long operation. It is issued on the left channel with lft_op = bits [29:0] and iss_kind = 1. rgt_vld stays 0 for the whole packet, and the packet ends when the left slot completes.
- R3: A word with bits [31:30] = 01 issues the left slot (bits [29:15], zero-extended on lft_op) first and the right slot (bits [14:0] on rgt_op) second, with iss_kind = 2.
- R4: A word with bits [31:30] = 10 issues the right slot first and the left slot second, with iss_kind = 3.
- R5: In an ordered pair the second slot is dropped when the first completes with ex_pc_chg or ex_exc set. skip_br pulses together with word_done only when ex_pc_chg is set and ex_exc is clear.
- R6: A word with bits [31:30] = 00 and a condition-test flag set is a parallel pair. The test slot issues first: the left slot when test_l is set (iss_kind = 5, and left wins if both flags are set), otherwise the right slot (iss_kind = 6). The partner issues only if the test completes with ex_cond set. Otherwise cond_false pulses together with word_done.
- R7: A word with bits [31:30] = 00 and neither test flag set is a plain parallel pair (iss_kind = 4). The left slot issues first, and the right slot issues only if the left completed without ex_exc.
- R8: lft_grp is word bits [29:24], which are bits [14:9] of the left slot and also bits [29:24] of a long payload. rgt_grp is word bits [14:9].
- R9: A slot's valid strobe holds until that slot's done input is seen. A done on the channel that is not valid has no effect. word_done pulses for one cycle in the cycle after the packet's final done edge, and word_ready is 1 in that same cycle.
- R10: At most one of lft_vld and rgt_vld is 1 at a time. A word is accepted only while word_ready is 1, and word_valid has no effect while a packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Fetch word offered |
| word_in | input | 32 | Fetched instruction word |
| test_l | input | 1 | Left short slot is a condition-test-only operation |
| test_r | input | 1 | Right short slot is a condition-test-only operation |
| word_ready | output | 1 | Block is idle and accepts a word |
| lft_vld | output | 1 | Left channel slot is issued |
| lft_op | output | 30 | Long payload or zero-extended left short slot |
| lft_grp | output | 6 | Opcode-group index of the left channel |
| rgt_vld | output | 1 | Right channel slot is issued |
| rgt_op | output | 15 | Right short slot |
| rgt_grp | output | 6 | Opcode-group index of the right channel |
| iss_kind | output | 3 | Issue pattern of the packet in progress |
| lft_done | input | 1 | Execute stage finished the left slot |
| rgt_done | input | 1 | Execute stage finished the right slot |
| ex_pc_chg | input | 1 | Finished slot redirected the PC |
| ex_exc | input | 1 | Finished slot raised an exception |
| ex_cond | input | 1 | Condition flag produced by the finished slot |
| word_done | output | 1 | One-cycle pulse: packet complete |
| skip_br | output | 1 | One-cycle pulse: second slot dropped by a branch |
| cond_false | output | 1 | One-cycle pulse: partner dropped by a false test |

## Verification
A corrupted latched kind or sequencer state shows up at the ports in the very next cycle. The wrong channel raises its valid strobe, or the wrong payload appears, and iss_kind no longer matches the format bits of the accepted word. A wrong decision on the second slot shows one cycle after the first done edge. Either a valid strobe appears where word_done was due, or the reverse, and the skip_br or cond_false pulse is missing or extra. The bench checks each of these at the cycle where it must first appear. It also sends stray done strobes and busy-time words, because a state machine that listens to them drifts by a full packet.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_LONG  = 3'd1,
    K_LR    = 3'd2,
    K_RL    = 3'd3,
    K_PAR   = 3'd4,
    K_TST_L = 3'd5,
    K_TST_R = 3'd6
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_FIRST  = 2'd1,
    S_SECOND = 2'd2
  } st_e;
endpackage

// File: rtl/dss_classify.sv
module dss_classify
  import dss_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              test_l,
  input  logic              test_r,
  output kind_e             kind
);
  logic [1:0] fmt;
  assign fmt = word[WORD_W-1 -: 2];

  always_comb begin
    case (fmt)
      2'b11:   kind = K_LONG;
      2'b01:   kind = K_LR;
      2'b10:   kind = K_RL;
      default: begin
        if (test_l)      kind = K_TST_L;
        else if (test_r) kind = K_TST_R;
        else             kind = K_PAR;
      end
    endcase
  end
endmodule

// File: rtl/dss_fields.sv
module dss_fields
  import dss_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 15,
  parameter int GRP_W  = 6,
  localparam int LONG_W = WORD_W - 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic              is_long,
  output logic [LONG_W-1:0] lft_op,
  output logic [GRP_W-1:0]  lft_grp,
  output logic [SLOT_W-1:0] rgt_op,
  output logic [GRP_W-1:0]  rgt_grp
);
  logic [SLOT_W-1:0] slot [2];
  logic [GRP_W-1:0]  grp  [2];

  // slot 0 = right (low), slot 1 = left (high)
  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign slot[s] = word[s*SLOT_W +: SLOT_W];
    assign grp[s]  = slot[s][SLOT_W-1 -: GRP_W];
  end

  always_comb begin
    if (is_long) lft_op = word[LONG_W-1:0];
    else         lft_op = {{(LONG_W-SLOT_W){1'b0}}, slot[1]};
  end

  // the left short slot's group bits coincide with the long group bits
  assign lft_grp = grp[1];
  assign rgt_op  = slot[0];
  assign rgt_grp = grp[0];
endmodule

// File: rtl/dss_ctl.sv
module dss_ctl
  import dss_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  word_valid,
  input  kind_e kind_in,
  input  logic  lft_done,
  input  logic  rgt_done,
  input  logic  ex_pc_chg,
  input  logic  ex_exc,
  input  logic  ex_cond,
  output logic  load,
  output logic  word_ready,
  output kind_e kind_out,
  output logic  lft_vld,
  output logic  rgt_vld,
  output logic  word_done,
  output logic  skip_br,
  output logic  cond_false
);
  st_e   st_q, st_d;
  kind_e kind_q, kind_d;
  logic  wd_q, wd_d, sk_q, sk_d, cf_q, cf_d;
  logic  first_r, act_done, go;

  assign first_r  = (kind_q == K_RL) || (kind_q == K_TST_R);
  assign lft_vld  = ((st_q == S_FIRST) && !first_r) || ((st_q == S_SECOND) && first_r);
  assign rgt_vld  = ((st_q == S_FIRST) && first_r)  || ((st_q == S_SECOND) && !first_r);
  assign act_done = (lft_vld && lft_done) || (rgt_vld && rgt_done);
  assign load     = (st_q == S_IDLE) && word_valid;

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    wd_d   = 1'b0;
    sk_d   = 1'b0;
    cf_d   = 1'b0;
    go     = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (word_valid) begin
          st_d   = S_FIRST;
          kind_d = kind_in;
        end
      end
      S_FIRST: begin
        if (act_done) begin
          case (kind_q)
            K_LR, K_RL: begin
              go   = !(ex_pc_chg || ex_exc);
              sk_d = ex_pc_chg && !ex_exc;
            end
            K_TST_L, K_TST_R: begin
              go   = ex_cond;
              cf_d = !ex_cond;
            end
            K_PAR:   go = !ex_exc;
            default: go = 1'b0;
          endcase
          st_d = go ? S_SECOND : S_IDLE;
          wd_d = !go;
        end
      end
      S_SECOND: begin
        if (act_done) begin
          st_d = S_IDLE;
          wd_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_NONE;
      wd_q   <= 1'b0;
      sk_q   <= 1'b0;
      cf_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      wd_q   <= wd_d;
      sk_q   <= sk_d;
      cf_q   <= cf_d;
    end
  end

  assign word_ready = (st_q == S_IDLE);
  assign kind_out   = (st_q == S_IDLE) ? K_NONE : kind_q;
  assign word_done  = wd_q;
  assign skip_br    = sk_q;
  assign cond_false = cf_q;
endmodule

// File: rtl/dual_slot_seq.sv
module dual_slot_seq
  import dss_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 15,
  parameter int GRP_W  = 6,
  localparam int LONG_W = WORD_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic              test_l,
  input  logic              test_r,
  output logic              word_ready,
  output logic              lft_vld,
  output logic [LONG_W-1:0] lft_op,
  output logic [GRP_W-1:0]  lft_grp,
  output logic              rgt_vld,
  output logic [SLOT_W-1:0] rgt_op,
  output logic [GRP_W-1:0]  rgt_grp,
  output logic [2:0]        iss_kind,
  input  logic              lft_done,
  input  logic              rgt_done,
  input  logic              ex_pc_chg,
  input  logic              ex_exc,
  input  logic              ex_cond,
  output logic              word_done,
  output logic              skip_br,
  output logic              cond_false
);
  kind_e             kind_new, kind_cur;
  logic              load;
  logic [WORD_W-1:0] word_q;

  dss_classify #(.WORD_W(WORD_W)) cls_i (
    .word   (word_in),
    .test_l (test_l),
    .test_r (test_r),
    .kind   (kind_new)
  );

  dss_ctl ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .kind_in    (kind_new),
    .lft_done   (lft_done),
    .rgt_done   (rgt_done),
    .ex_pc_chg  (ex_pc_chg),
    .ex_exc     (ex_exc),
    .ex_cond    (ex_cond),
    .load       (load),
    .word_ready (word_ready),
    .kind_out   (kind_cur),
    .lft_vld    (lft_vld),
    .rgt_vld    (rgt_vld),
    .word_done  (word_done),
    .skip_br    (skip_br),
    .cond_false (cond_false)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  dss_fields #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .GRP_W(GRP_W)) fld_i (
    .word    (word_q),
    .is_long (kind_cur == K_LONG),
    .lft_op  (lft_op),
    .lft_grp (lft_grp),
    .rgt_op  (rgt_op),
    .rgt_grp (rgt_grp)
  );

  assign iss_kind = kind_cur;
endmodule

// File: rtl/dual_slot_seq_chk.sv
module dual_slot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       word_ready,
  input logic       lft_vld,
  input logic       rgt_vld,
  input logic       lft_done,
  input logic       rgt_done,
  input logic [2:0] iss_kind,
  input logic       word_done,
  input logic       skip_br,
  input logic       cond_false
);
  // R10
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lft_vld && rgt_vld));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> (!lft_vld && !rgt_vld));
  // R9
  lft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_vld && !lft_done) |=> lft_vld);
  // R9
  rgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgt_vld && !rgt_done) |=> rgt_vld);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> word_ready);
  // R5
  skip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_br |-> word_done);
  // R6
  cf_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_false |-> word_done);
  // R2
  long_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_kind == 3'd1) |-> !rgt_vld);
endmodule

bind dual_slot_seq dual_slot_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_ready (word_ready),
  .lft_vld    (lft_vld),
  .rgt_vld    (rgt_vld),
  .lft_done   (lft_done),
  .rgt_done   (rgt_done),
  .iss_kind   (iss_kind),
  .word_done  (word_done),
  .skip_br    (skip_br),
  .cond_false (cond_false)
);

// File: tb/dual_slot_seq_tb_top.sv
module dual_slot_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_valid, test_l, test_r;
  logic [31:0] word_in;
  logic        word_ready, lft_vld, rgt_vld;
  logic [29:0] lft_op;
  logic [5:0]  lft_grp, rgt_grp;
  logic [14:0] rgt_op;
  logic [2:0]  iss_kind;
  logic        lft_done, rgt_done, ex_pc_chg, ex_exc, ex_cond;
  logic        word_done, skip_br, cond_false;

  int nchk = 0;
  int nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_slot_seq dut_i (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
    .test_l(test_l), .test_r(test_r), .word_ready(word_ready),
    .lft_vld(lft_vld), .lft_op(lft_op), .lft_grp(lft_grp),
    .rgt_vld(rgt_vld), .rgt_op(rgt_op), .rgt_grp(rgt_grp),
    .iss_kind(iss_kind), .lft_done(lft_done), .rgt_done(rgt_done),
    .ex_pc_chg(ex_pc_chg), .ex_exc(ex_exc), .ex_cond(ex_cond),
    .word_done(word_done), .skip_br(skip_br), .cond_false(cond_false)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_kind(input logic [31:0] w, input logic tl, input logic tr);
    case (w[31:30])
      2'b11: return 3'd1;
      2'b01: return 3'd2;
      2'b10: return 3'd3;
      default: return tl ? 3'd5 : (tr ? 3'd6 : 3'd4);
    endcase
  endfunction

  function automatic logic first_right(input logic [2:0] k);
    return (k == 3'd3) || (k == 3'd6);
  endfunction

  // check the outputs while one slot (left or right) is the only one issued
  task automatic chk_slot(input logic right, input logic [2:0] k, input logic [31:0] w);
    chk("R10 lft_vld", lft_vld, !right);
    chk("R10 rgt_vld", rgt_vld, right);
    if (right) begin
      chk("R3/R4 rgt_op", rgt_op, w[14:0]);
      chk("R8 rgt_grp", rgt_grp, w[14:9]);
    end else begin
      chk("R2/R3 lft_op", lft_op, (k == 3'd1) ? w[29:0] : {15'b0, w[29:15]});
      chk("R8 lft_grp", lft_grp, w[29:24]);
    end
  endtask

  task automatic do_pkt(input logic [31:0] w, input logic tl, input logic tr,
                        input logic pc, input logic ex, input logic cd,
                        input logic ex2, input logic stray);
    logic [2:0] k;
    logic fr, go, sk, cf;
    k  = exp_kind(w, tl, tr);
    fr = first_right(k);
    @(negedge clk);
    word_valid = 1'b1; word_in = w; test_l = tl; test_r = tr;
    @(negedge clk);
    word_valid = 1'b0;
    chk("R6 iss_kind", iss_kind, k);
    chk("R10 busy", word_ready, 1'b0);
    chk_slot(fr, k, w);
    if (stray) begin
      // done on the idle channel and a new word while busy: both ignored
      lft_done = fr; rgt_done = !fr;
      word_valid = 1'b1; word_in = ~w; test_l = ~tl; test_r = ~tr;
      @(negedge clk);
      lft_done = 1'b0; rgt_done = 1'b0; word_valid = 1'b0;
      chk("R9 stray done", {word_done, iss_kind}, {1'b0, k});
      chk_slot(fr, k, w);
    end
    lft_done = !fr; rgt_done = fr;
    ex_pc_chg = pc; ex_exc = ex; ex_cond = cd;
    @(negedge clk);
    lft_done = 1'b0; rgt_done = 1'b0;
    case (k)
      3'd2, 3'd3: begin go = !(pc || ex); sk = pc && !ex; cf = 1'b0; end
      3'd5, 3'd6: begin go = cd; sk = 1'b0; cf = !cd; end
      3'd4:       begin go = !ex; sk = 1'b0; cf = 1'b0; end
      default:    begin go = 1'b0; sk = 1'b0; cf = 1'b0; end
    endcase
    if (go) begin
      chk("R7 no early done", word_done, 1'b0);
      chk_slot(!fr, k, w);
      lft_done = fr; rgt_done = !fr; ex_exc = ex2; ex_pc_chg = ex2;
      @(negedge clk);
      lft_done = 1'b0; rgt_done = 1'b0;
      chk("R9 word_done", word_done, 1'b1);
      chk("R5 skip_br", skip_br, 1'b0);
      chk("R6 cond_false", cond_false, 1'b0);
    end else begin
      chk("R9 word_done", word_done, 1'b1);
      chk("R5 skip_br", skip_br, sk);
      chk("R6 cond_false", cond_false, cf);
    end
    chk("R9 ready", word_ready, 1'b1);
    chk("R10 no vld", {lft_vld, rgt_vld}, 2'b00);
    ex_pc_chg = 1'b0; ex_exc = 1'b0; ex_cond = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; word_valid = 1'b0; word_in = '0; test_l = 1'b0; test_r = 1'b0;
    lft_done = 1'b0; rgt_done = 1'b0; ex_pc_chg = 1'b0; ex_exc = 1'b0; ex_cond = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ready", word_ready, 1'b1);
    chk("R1 vld", {lft_vld, rgt_vld}, 2'b00);
    chk("R1 kind", iss_kind, 3'd0);
    chk("R1 pulses", {word_done, skip_br, cond_false}, 3'b000);
    rst_n = 1'b1;
    // directed corners
    do_pkt(32'hC5A5_1234, 0, 0, 0, 0, 0, 0, 1); // R2 long
    do_pkt(32'h5F0F_A0A5, 0, 0, 0, 0, 0, 0, 1); // R3 left then right
    do_pkt(32'h9234_5678, 0, 0, 0, 0, 0, 0, 0); // R4 right then left
    do_pkt(32'h5555_AAAA, 0, 0, 1, 0, 0, 0, 0); // R5 branch skip
    do_pkt(32'h9555_AAAA, 0, 0, 1, 1, 0, 0, 0); // R5 branch with exception: no skip pulse
    do_pkt(32'h4321_8765, 0, 0, 0, 1, 0, 0, 0); // R5 exception drop
    do_pkt(32'h1234_4321, 1, 0, 0, 0, 0, 0, 1); // R6 left test false
    do_pkt(32'h2468_1357, 0, 1, 0, 0, 1, 0, 0); // R6 right test true
    do_pkt(32'h3FFF_FFFF, 1, 1, 0, 0, 1, 0, 0); // R6 both tests, left wins
    do_pkt(32'h0ABC_DEF0, 0, 0, 0, 1, 0, 0, 0); // R7 exception drop
    do_pkt(32'h0000_0000, 0, 0, 1, 0, 0, 0, 0); // R7 pc change alone does not drop
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      do_pkt($urandom, r[0], r[1], r[2], r[3], r[4], r[5], r[6]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule